// File: doc/BRIEF.md
# Host Wake Handshake Controller

This block is a general-purpose control word through which a host brings an internal processor domain to full power and keeps it awake. The host writes two control bits. An init flag asks for full-power operation, and an access-request flag pins the domain awake. The block answers with a clock-ready flag, a going-to-sleep warning, a three-bit power-save mode field, the level of an external RF-kill switch and the board strap pins. All of these are packed into one status word.

A small sequencer models the domain's power states. It has a power-up delay, an awake state, a sleep-warning window and a power-down delay, and each delay is a parameter in clock cycles. The domain may ask to sleep through `dom_sleep_req`. That request is honoured only when the host is not holding access-request. A request that arrives during the warning window aborts the sleep. The host may touch internal resources only while `access_granted` is high, which means clock-ready is set and no sleep warning is showing. A change of the RF-kill switch level raises a one-cycle event.

Top module: `pwr_hs_ctrl`

## Requirements
- R1: After synchronous reset the status word holds only the strap pins (bits 9:6) and mode 001 (bits 26:24). `access_granted` and `rfkill_evt` are 0.
- R2: Clock-ready (bit 0) stays 0 until the host has set init (bit 2), whatever the access-request bit and `dom_sleep_req` do.
- R3: A host write that sets init, while the domain is off and the domain is willing to wake, raises clock-ready exactly UP_CYC+2 rising edges after the write, counting the edge that captures the write.
- R4: A host write stores bit 2 (init) and bit 3 (access-request) of the write data and ignores every other bit. Bits not defined in R1, R5, R9, R10 and R11 read as 0.
- R5: When the domain is awake and the wake condition (init AND (access-request OR NOT `dom_sleep_req`)) goes false, going-to-sleep (bit 4) is high for WARN_CYC cycles while clock-ready stays high. Clock-ready then drops and stays low for DOWN_CYC cycles before a new power-up may start, so a domain that wants to wake at once sees clock-ready low for DOWN_CYC+UP_CYC+1 cycles.
- R6: If the wake condition returns during the warning window, going-to-sleep clears one cycle later and clock-ready never drops.
- R7: While init and access-request are both set, an awake domain stays awake even with `dom_sleep_req` high.
- R8: `access_granted` is high exactly when clock-ready is 1 and going-to-sleep is 0.
- R9: The mode field is chosen by priority. It is 011 when access-request is set without init, otherwise 001 when the domain is off or powering down, otherwise 010 when the RF-kill level is 1, otherwise 000.
- R10: Bit 27 follows `rfkill_sw` through SYNC_STAGES synchronizer flops plus one level flop. `rfkill_evt` is high for exactly the one cycle in which bit 27 changes.
- R11: Bits 9:6 reflect `strap_pins` directly.
- R12: Clearing init while the domain is awake powers it down through the warning window, even with access-request held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe for the control word |
| host_wr_data | input | 32 | Host write data; only bits 2 and 3 are kept |
| dom_sleep_req | input | 1 | Domain asks to enter power-down |
| rfkill_sw | input | 1 | Asynchronous RF-kill switch level |
| strap_pins | input | 4 | Board configuration straps |
| status_word | output | 32 | Packed control and status word |
| access_granted | output | 1 | Internal access is legal this cycle |
| rfkill_evt | output | 1 | One-cycle pulse on an RF-kill level change |

## Verification
The sequencer is driven with four directed patterns, and each one separates a different behaviour:
- An access request without init shows that clock-ready cannot rise early and that the error mode appears.
- Init with the domain willing pins down the exact power-up latency.
- Dropping access-request while the domain wants to sleep measures the warning length and the off interval.
- Re-asserting access-request inside the warning window tells an abort apart from a completed power-down.

A long random phase then mixes host writes, sleep requests, switch toggles and strap changes. Its results are compared every cycle against a bench-side model of the status word, the grant and the event, which exposes ordering bugs between these inputs.

// File: rtl/pwr_hs_pkg.sv
`timescale 1ns/1ps
package pwr_hs_pkg;

    localparam int WORD_W    = 32;
    localparam int BIT_RDY   = 0;
    localparam int BIT_INIT  = 2;
    localparam int BIT_ACC   = 3;
    localparam int BIT_GTS   = 4;
    localparam int STRAP_LSB = 6;
    localparam int STRAP_W   = 4;
    localparam int MODE_LSB  = 24;
    localparam int MODE_W    = 3;
    localparam int BIT_RFK   = 27;

    localparam logic [WORD_W-1:0] WR_MASK =
        (WORD_W'(1) << BIT_INIT) | (WORD_W'(1) << BIT_ACC);

    typedef enum logic [2:0] {
        PS_OFF,
        PS_UP,
        PS_AWAKE,
        PS_WARN,
        PS_DOWN
    } pwr_state_e;

    typedef enum logic [MODE_W-1:0] {
        PSM_NONE  = 3'b000,
        PSM_MAC   = 3'b001,
        PSM_RADIO = 3'b010,
        PSM_ERR   = 3'b011
    } ps_mode_e;

    typedef struct packed {
        logic init_done;
        logic access_req;
    } host_ctl_t;

    typedef struct packed {
        logic clk_ready;
        logic going_sleep;
        logic domain_off;
    } seq_stat_t;

    function automatic logic wake_wanted(host_ctl_t h, logic sleep_req);
        return h.init_done && (h.access_req || !sleep_req);
    endfunction

    function automatic ps_mode_e pick_mode(host_ctl_t h, logic dom_off, logic rfk);
        if (h.access_req && !h.init_done) return PSM_ERR;
        if (dom_off)                       return PSM_MAC;
        if (rfk)                           return PSM_RADIO;
        return PSM_NONE;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(
        host_ctl_t            h,
        seq_stat_t            s,
        logic [STRAP_W-1:0]   strap,
        ps_mode_e             m,
        logic                 rfk
    );
        logic [WORD_W-1:0] w;
        w = '0;
        w[BIT_RDY]                       = s.clk_ready;
        w[BIT_INIT]                      = h.init_done;
        w[BIT_ACC]                       = h.access_req;
        w[BIT_GTS]                       = s.going_sleep;
        w[STRAP_LSB +: STRAP_W]          = strap;
        w[MODE_LSB +: MODE_W]            = m;
        w[BIT_RFK]                       = rfk;
        return w;
    endfunction

endpackage

// File: rtl/pwr_hs_hostreg.sv
`timescale 1ns/1ps
module pwr_hs_hostreg
    import pwr_hs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output host_ctl_t         ctl
);

    logic [WORD_W-1:0] ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (wr_en) begin
            ctl_q <= (ctl_q & ~WR_MASK) | (wr_data & WR_MASK);
        end
    end

    always_comb begin
        ctl.init_done  = ctl_q[BIT_INIT];
        ctl.access_req = ctl_q[BIT_ACC];
    end

endmodule

// File: rtl/pwr_hs_seq.sv
`timescale 1ns/1ps
module pwr_hs_seq
    import pwr_hs_pkg::*;
#(
    parameter int UP_CYC   = 6,
    parameter int WARN_CYC = 4,
    parameter int DOWN_CYC = 5
) (
    input  logic      clk,
    input  logic      rst,
    input  host_ctl_t ctl,
    input  logic      dom_sleep_req,
    output seq_stat_t stat
);

    localparam int MAX_A   = (UP_CYC > WARN_CYC) ? UP_CYC : WARN_CYC;
    localparam int MAX_CYC = (MAX_A > DOWN_CYC) ? MAX_A : DOWN_CYC;
    localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
    localparam logic [CNT_W-1:0] UP_LAST   = CNT_W'(UP_CYC - 1);
    localparam logic [CNT_W-1:0] WARN_LAST = CNT_W'(WARN_CYC - 1);
    localparam logic [CNT_W-1:0] DOWN_LAST = CNT_W'(DOWN_CYC - 1);

    pwr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             wake;

    assign wake = wake_wanted(ctl, dom_sleep_req);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PS_OFF: begin
                if (wake) begin
                    state_d = PS_UP;
                    cnt_d   = '0;
                end
            end
            PS_UP: begin
                if (cnt_q == UP_LAST) state_d = PS_AWAKE;
                else                  cnt_d   = cnt_q + 1'b1;
            end
            PS_AWAKE: begin
                if (!wake) begin
                    state_d = PS_WARN;
                    cnt_d   = '0;
                end
            end
            PS_WARN: begin
                if (wake) begin
                    state_d = PS_AWAKE;
                end else if (cnt_q == WARN_LAST) begin
                    state_d = PS_DOWN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            PS_DOWN: begin
                if (cnt_q == DOWN_LAST) state_d = PS_OFF;
                else                    cnt_d   = cnt_q + 1'b1;
            end
            default: state_d = PS_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        stat.clk_ready   = (state_q == PS_AWAKE) || (state_q == PS_WARN);
        stat.going_sleep = (state_q == PS_WARN);
        stat.domain_off  = (state_q == PS_OFF) || (state_q == PS_DOWN);
    end

endmodule

// File: rtl/pwr_hs_rfk.sv
`timescale 1ns/1ps
module pwr_hs_rfk #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sw_in,
    output logic level,
    output logic toggle_evt
);

    logic [SYNC_STAGES-1:0] sh_q;
    logic                   level_q;
    logic                   evt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            level_q <= 1'b0;
            evt_q   <= 1'b0;
        end else begin
            sh_q[0] <= sw_in;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                sh_q[i] <= sh_q[i-1];
            end
            level_q <= sh_q[SYNC_STAGES-1];
            evt_q   <= sh_q[SYNC_STAGES-1] ^ level_q;
        end
    end

    assign level      = level_q;
    assign toggle_evt = evt_q;

endmodule

// File: rtl/pwr_hs_ctrl.sv
`timescale 1ns/1ps
module pwr_hs_ctrl
    import pwr_hs_pkg::*;
#(
    parameter int UP_CYC      = 6,
    parameter int WARN_CYC    = 4,
    parameter int DOWN_CYC    = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr_en,
    input  logic [WORD_W-1:0]  host_wr_data,
    input  logic               dom_sleep_req,
    input  logic               rfkill_sw,
    input  logic [STRAP_W-1:0] strap_pins,
    output logic [WORD_W-1:0]  status_word,
    output logic               access_granted,
    output logic               rfkill_evt
);

    host_ctl_t ctl;
    seq_stat_t stat;
    logic      rfk_level;
    ps_mode_e  mode;

    pwr_hs_hostreg u_hostreg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (host_wr_en),
        .wr_data (host_wr_data),
        .ctl     (ctl)
    );

    pwr_hs_seq #(
        .UP_CYC   (UP_CYC),
        .WARN_CYC (WARN_CYC),
        .DOWN_CYC (DOWN_CYC)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .ctl           (ctl),
        .dom_sleep_req (dom_sleep_req),
        .stat          (stat)
    );

    pwr_hs_rfk #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_rfk (
        .clk        (clk),
        .rst        (rst),
        .sw_in      (rfkill_sw),
        .level      (rfk_level),
        .toggle_evt (rfkill_evt)
    );

    always_comb begin
        mode           = pick_mode(ctl, stat.domain_off, rfk_level);
        status_word    = pack_word(ctl, stat, strap_pins, mode, rfk_level);
        access_granted = stat.clk_ready && !stat.going_sleep;
    end

endmodule

// File: rtl/pwr_hs_chk.sv
`timescale 1ns/1ps
module pwr_hs_chk
    import pwr_hs_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [WORD_W-1:0]  status_word,
    input logic               access_granted,
    input logic               rfkill_evt,
    input logic               dom_sleep_req,
    input logic [STRAP_W-1:0] strap_pins
);

    localparam logic [WORD_W-1:0] USED_MASK =
        (WORD_W'(1) << BIT_RDY) | (WORD_W'(1) << BIT_INIT) | (WORD_W'(1) << BIT_ACC) |
        (WORD_W'(1) << BIT_GTS) | (WORD_W'((1 << STRAP_W) - 1) << STRAP_LSB) |
        (WORD_W'((1 << MODE_W) - 1) << MODE_LSB) | (WORD_W'(1) << BIT_RFK);

    logic seen_init;

    always_ff @(posedge clk) begin
        if (rst)                         seen_init <= 1'b0;
        else if (status_word[BIT_INIT])  seen_init <= 1'b1;
    end

    AST_READY_NEEDS_INIT: assert property (@(posedge clk) disable iff (rst)
        !seen_init && !status_word[BIT_INIT] |-> !status_word[BIT_RDY]); // R2

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (status_word & ~USED_MASK) == '0); // R4

    AST_DROP_AFTER_WARN: assert property (@(posedge clk) disable iff (rst)
        $fell(status_word[BIT_RDY]) |-> $past(status_word[BIT_GTS])); // R5

    AST_ABORT_ON_WAKE: assert property (@(posedge clk) disable iff (rst)
        $fell(status_word[BIT_GTS]) && status_word[BIT_RDY] |->
        $past(status_word[BIT_INIT] && (status_word[BIT_ACC] || !dom_sleep_req))); // R6

    AST_HELD_AWAKE: assert property (@(posedge clk) disable iff (rst)
        status_word[BIT_RDY] && status_word[BIT_INIT] && status_word[BIT_ACC] |=>
        status_word[BIT_RDY]); // R7

    AST_GRANT_RULE: assert property (@(posedge clk) disable iff (rst)
        access_granted == (status_word[BIT_RDY] && !status_word[BIT_GTS])); // R8

    AST_ERR_MODE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        status_word[MODE_LSB +: MODE_W] == PSM_ERR |->
        status_word[BIT_ACC] && !status_word[BIT_INIT]); // R9

    AST_NO_MAC_DOWN_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
        status_word[BIT_RDY] && !(status_word[BIT_ACC] && !status_word[BIT_INIT]) |->
        status_word[MODE_LSB +: MODE_W] != PSM_MAC); // R9

    AST_EVT_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
        rfkill_evt == (status_word[BIT_RFK] != $past(status_word[BIT_RFK]))); // R10

    AST_STRAP_MIRROR: assert property (@(posedge clk) disable iff (rst)
        status_word[STRAP_LSB +: STRAP_W] == strap_pins); // R11

endmodule

bind pwr_hs_ctrl pwr_hs_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .status_word    (status_word),
    .access_granted (access_granted),
    .rfkill_evt     (rfkill_evt),
    .dom_sleep_req  (dom_sleep_req),
    .strap_pins     (strap_pins)
);

// File: tb/sim_pwr_hs_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_hs_ctrl;

    localparam int UP   = 6;
    localparam int WARN = 4;
    localparam int DOWN = 5;
    localparam int SYNC = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr_en = 1'b0;
    logic [31:0] host_wr_data = '0;
    logic        dom_sleep_req = 1'b0;
    logic        rfkill_sw = 1'b0;
    logic [3:0]  strap_pins = 4'b1010;
    logic [31:0] status_word;
    logic        access_granted;
    logic        rfkill_evt;

    int    n_total = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    pwr_hs_ctrl #(
        .UP_CYC (UP), .WARN_CYC (WARN), .DOWN_CYC (DOWN), .SYNC_STAGES (SYNC)
    ) u0 (
        .clk (clk), .rst (rst), .host_wr_en (host_wr_en), .host_wr_data (host_wr_data),
        .dom_sleep_req (dom_sleep_req), .rfkill_sw (rfkill_sw), .strap_pins (strap_pins),
        .status_word (status_word), .access_granted (access_granted), .rfkill_evt (rfkill_evt)
    );

    // reference model: 0 off, 1 up, 2 awake, 3 warn, 4 down
    int            m_st, m_cnt;
    bit            m_init, m_acc, m_rfk, m_evt, m_wake;
    bit [SYNC-1:0] m_sh;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_cnt = 0; m_init = 0; m_acc = 0; m_rfk = 0; m_evt = 0; m_sh = '0;
        end else begin
            m_wake = m_init && (m_acc || !dom_sleep_req);
            case (m_st)
                0: if (m_wake) begin m_st = 1; m_cnt = 0; end
                1: if (m_cnt == UP - 1) m_st = 2; else m_cnt++;
                2: if (!m_wake) begin m_st = 3; m_cnt = 0; end
                3: if (m_wake) m_st = 2;
                   else if (m_cnt == WARN - 1) begin m_st = 4; m_cnt = 0; end
                   else m_cnt++;
                default: if (m_cnt == DOWN - 1) m_st = 0; else m_cnt++;
            endcase
            m_evt = m_sh[SYNC-1] ^ m_rfk;
            m_rfk = m_sh[SYNC-1];
            m_sh  = {m_sh[SYNC-2:0], rfkill_sw};
            if (host_wr_en) begin
                m_init = host_wr_data[2];
                m_acc  = host_wr_data[3];
            end
        end
    end

    function automatic logic [31:0] exp_word();
        logic [31:0] w;
        logic [2:0]  md;
        if (m_acc && !m_init)         md = 3'b011;
        else if (m_st == 0 || m_st == 4) md = 3'b001;
        else if (m_rfk)               md = 3'b010;
        else                          md = 3'b000;
        w = '0;
        w[0]     = (m_st == 2) || (m_st == 3);
        w[2]     = m_init;
        w[3]     = m_acc;
        w[4]     = (m_st == 3);
        w[9:6]   = strap_pins;
        w[26:24] = md;
        w[27]    = m_rfk;
        return w;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        chk(cur_req, status_word, exp_word());
        chk("R8", {31'd0, access_granted}, {31'd0, m_st == 2});
        chk("R10", {31'd0, rfkill_evt}, {31'd0, m_evt});
    endtask

    task automatic host_write(logic [31:0] d);
        host_wr_en   = 1'b1;
        host_wr_data = d;
        tick();
        host_wr_en   = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1", status_word, 32'h0100_0280);
        chk("R1", {30'd0, access_granted, rfkill_evt}, 32'd0);

        // R4 write with init and access bits clear, everything else set
        cur_req = "R4";
        host_write(32'hFFFF_FFF3);
        chk("R4", status_word, 32'h0100_0280);

        // R2 access request without init, plus error mode (R9)
        cur_req = "R2";
        host_write(32'h0000_0008);
        repeat (20) tick();
        chk("R2", {31'd0, status_word[0]}, 32'd0);
        chk("R9", {29'd0, status_word[26:24]}, 32'd3);

        // R3 power-up latency
        cur_req = "R3";
        dom_sleep_req = 1'b0;
        host_write(32'h0000_000C);
        n = 1;
        while (!status_word[0] && n < 100) begin tick(); n++; end
        chk("R3", n, UP + 2);
        chk("R8", {31'd0, access_granted}, 32'd1);

        // R7 access request holds the domain awake
        cur_req = "R7";
        dom_sleep_req = 1'b1;
        n = 0;
        repeat (30) begin tick(); if (!status_word[0]) n++; end
        chk("R7", n, 0);

        // R5 sleep warning and power-down interval
        cur_req = "R5";
        host_write(32'h0000_0004);
        n = 0;
        while (!status_word[4] && n < 50) begin tick(); n++; end
        n = 0;
        while (status_word[4] && n < 50) begin
            chk("R5", {31'd0, status_word[0]}, 32'd1);
            chk("R8", {31'd0, access_granted}, 32'd0);
            tick(); n++;
        end
        chk("R5", n, WARN);
        chk("R5", {31'd0, status_word[0]}, 32'd0);
        dom_sleep_req = 1'b0;
        n = 0;
        while (!status_word[0] && n < 100) begin tick(); n++; end
        chk("R5", n, DOWN + UP + 1);

        // R6 abort inside the warning window
        cur_req = "R6";
        dom_sleep_req = 1'b1;
        n = 0;
        while (!status_word[4] && n < 50) begin tick(); n++; end
        tick();
        host_write(32'h0000_000C);
        chk("R6", {31'd0, status_word[4]}, 32'd1);
        tick();
        chk("R6", {30'd0, status_word[4], status_word[0]}, 32'd1);

        // R12 clearing init powers down with access held
        cur_req = "R12";
        dom_sleep_req = 1'b0;
        host_write(32'h0000_0008);
        n = 0;
        while (status_word[0] && n < 60) begin tick(); n++; end
        chk("R12", {31'd0, status_word[0]}, 32'd0);
        chk("R9", {29'd0, status_word[26:24]}, 32'd3);

        // R10 switch synchronizer latency and event pulse
        cur_req = "R10";
        rfkill_sw = 1'b1;
        n = 0;
        while (!rfkill_evt && n < 20) begin tick(); n++; end
        chk("R10", n, SYNC + 1);
        chk("R10", {31'd0, status_word[27]}, 32'd1);
        tick();
        chk("R10", {31'd0, rfkill_evt}, 32'd0);

        // R9 radio power-down mode while awake with switch on
        cur_req = "R9";
        host_write(32'h0000_0004);
        n = 0;
        while (!status_word[0] && n < 60) begin tick(); n++; end
        chk("R9", {29'd0, status_word[26:24]}, 32'd2);

        // R11 straps mirrored
        cur_req = "R11";
        strap_pins = 4'b0101;
        tick();
        chk("R11", {28'd0, status_word[9:6]}, 32'h5);

        // random phase checked every cycle against the model
        cur_req = "R5 random";
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(99) < 8) begin
                host_wr_en   = 1'b1;
                host_wr_data = $urandom;
            end else begin
                host_wr_en   = 1'b0;
            end
            if ($urandom_range(99) < 6) dom_sleep_req = ~dom_sleep_req;
            if ($urandom_range(99) < 3) rfkill_sw = ~rfkill_sw;
            if ($urandom_range(99) < 2) strap_pins = 4'($urandom);
            tick();
        end
        host_wr_en = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule